// File: doc/BRIEF.md
# Receive frame buffer write guard

This block decides whether a newly received radio frame may be written into a single frame buffer. When the guard is switched on and the transceiver is in a receive-listening state, a stored frame is locked against overwrite by later over-the-air frames. The lock holds until the host finishes reading the buffer through its serial access port, or until the transceiver leaves the listening states. While the lock is off, each new frame simply replaces the previous one.

The arming condition depends on the operating mode. In basic mode only a frame with a good checksum arms the lock. In extended mode every receive-end event arms it, whatever the checksum. The guard gates air-side writes only. Host writes into the buffer travel on a separate path that this block does not touch. The guard's enable bit sits in a small control register, next to a two-bit data-rate field that is stored independently of the guard.

Top module: `fbuf_guard`

## Requirements
- R1: After a synchronous reset, `is_protected` is 0, `air_wr_en` is 1 and `cfg_rd` is 0x00.
- R2: A write with `reg_we`=1 and `reg_addr`=0x0C loads the guard enable from `reg_wdata[7]` and the data-rate field from `reg_wdata[1:0]`. `cfg_rd` shows {enable, 5'b0, rate}, so bits 6:2 always read 0. A write to any other address leaves `cfg_rd` unchanged.
- R3: In basic mode (`ext_mode`=0), with the guard enabled and `trx_state` at 0x06 or 0x16, a `rx_done` pulse with `rx_crc_ok`=1 sets `is_protected` to 1 and `air_wr_en` to 0 on the next clock edge.
- R4: In basic mode, a `rx_done` pulse with `rx_crc_ok`=0 does not arm protection.
- R5: In extended mode (`ext_mode`=1), a `rx_done` pulse arms protection whatever the value of `rx_crc_ok`.
- R6: The guard releases protection when the host ends a frame-buffer read. That is a rising edge of `host_cs_n` after an access during which `host_fb_rd` was 1. The release shows at the third rising clock edge after `host_cs_n` rises: two synchroniser stages, then the state update.
- R7: A rising edge of `host_cs_n` that ends an access during which `host_fb_rd` stayed 0 does not release protection.
- R8: When `trx_state` is neither 0x06 nor 0x16, protection is cleared at the next edge and cannot arm.
- R9: Clearing the enable bit while protected releases protection on the edge after the register write takes effect.
- R10: With the enable bit at 0, received frames never arm protection, and `air_wr_en` stays 1.
- R11: If an arming `rx_done` falls in the same cycle as a frame-buffer-read release, protection stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 6 | Control register address |
| reg_wdata | input | 8 | Control register write data |
| cfg_rd | output | 8 | Current control register contents |
| trx_state | input | 5 | Transceiver state code (0x06 plain receive, 0x16 auto-ack receive) |
| rx_done | input | 1 | One-cycle receive-end strobe |
| rx_crc_ok | input | 1 | Checksum valid for the frame ending with rx_done |
| ext_mode | input | 1 | 0 = basic mode, 1 = extended mode |
| host_cs_n | input | 1 | Asynchronous active-low host select |
| host_fb_rd | input | 1 | Current host access is a frame-buffer read |
| air_wr_en | output | 1 | Air-side frame may be written into the buffer |
| is_protected | output | 1 | Buffer contents are locked |

## Verification
The assertions check the arming and blocking rules on every cycle. A checked arm in either mode must set the lock. A bad checksum in basic mode must leave the lock clear. A disabled guard or a non-listening state must leave the lock clear on the next edge. The register must hold its value when it is not written. The host read release and its three-edge latency, the non-buffer access that must not release, and the arm-beats-release collision depend on host access sequences. The bench's directed scenarios cover these.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int STATE_W    = 5;
    localparam int RATE_W     = 2;
    localparam int EN_BIT     = 7;
    localparam logic [ADDR_W-1:0]  CTRL_ADDR   = 6'h0C;
    localparam logic [STATE_W-1:0] ST_RX_PLAIN = 5'h06;
    localparam logic [STATE_W-1:0] ST_RX_ACK   = 5'h16;

    typedef enum logic { MODE_BASIC = 1'b0, MODE_EXT = 1'b1 } op_mode_e;

    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    function automatic logic is_listening(input logic [STATE_W-1:0] st);
        return (st == ST_RX_PLAIN) || (st == ST_RX_ACK);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EN_BIT]       = c.en;
        v[RATE_W-1:0]   = c.rate;
        return v;
    endfunction
endpackage

// File: rtl/fbg_ctrl_reg.sv
module fbg_ctrl_reg
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && addr == CTRL_ADDR) begin
            ctrl.en   <= wdata[EN_BIT];
            ctrl.rate <= wdata[RATE_W-1:0];
        end
    end
endmodule

// File: rtl/fbg_cs_sync.sv
module fbg_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic fb_rd,
    output logic fb_read_end
);
    logic [STAGES-1:0] chain;
    logic              cs_prev;
    logic              fb_seen;
    logic              cs_s;
    logic              rise;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= cs_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign cs_s = chain[STAGES-1];
    assign rise = cs_s && !cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev <= 1'b1;
            fb_seen <= 1'b0;
        end else begin
            cs_prev <= cs_s;
            if (rise)
                fb_seen <= 1'b0;
            else if (!cs_s && fb_rd)
                fb_seen <= 1'b1;
        end
    end

    assign fb_read_end = rise && fb_seen;
endmodule

// File: rtl/fbg_arm_fsm.sv
module fbg_arm_fsm
    import fbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     listening,
    input  logic     rx_done,
    input  logic     crc_ok,
    input  op_mode_e mode,
    input  logic     read_end,
    output logic     armed
);
    logic frame_qualifies;
    logic arm_ev;
    logic release_ev;

    always_comb begin
        unique case (mode)
            MODE_EXT:   frame_qualifies = 1'b1;
            default:    frame_qualifies = crc_ok;
        endcase
        arm_ev     = enable && listening && rx_done && frame_qualifies;
        release_ev = !enable || !listening || read_end;
    end

    always_ff @(posedge clk) begin
        if (rst)             armed <= 1'b0;
        else if (arm_ev)     armed <= 1'b1;
        else if (release_ev) armed <= 1'b0;
    end
endmodule

// File: rtl/fbuf_guard.sv
module fbuf_guard
    import fbg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  cfg_rd,
    input  logic [STATE_W-1:0] trx_state,
    input  logic               rx_done,
    input  logic               rx_crc_ok,
    input  logic               ext_mode,
    input  logic               host_cs_n,
    input  logic               host_fb_rd,
    output logic               air_wr_en,
    output logic               is_protected
);
    ctrl_t ctrl;
    logic  read_end;
    logic  armed;

    fbg_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    fbg_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (host_cs_n),
        .fb_rd       (host_fb_rd),
        .fb_read_end (read_end)
    );

    fbg_arm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.en),
        .listening (is_listening(trx_state)),
        .rx_done   (rx_done),
        .crc_ok    (rx_crc_ok),
        .mode      (op_mode_e'(ext_mode)),
        .read_end  (read_end),
        .armed     (armed)
    );

    assign cfg_rd       = pack_ctrl(ctrl);
    assign is_protected = armed;
    assign air_wr_en    = !armed;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
    import fbg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  cfg_rd,
    input logic [STATE_W-1:0] trx_state,
    input logic               rx_done,
    input logic               rx_crc_ok,
    input logic               ext_mode,
    input logic               is_protected
);
    logic listen;
    assign listen = (trx_state == 5'h06) || (trx_state == 5'h16);

    a_r3_arm_basic: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd[7] && listen && rx_done && !ext_mode && rx_crc_ok) |=> is_protected);

    a_r4_bad_crc_basic: assert property (@(posedge clk) disable iff (rst)
        (!is_protected && rx_done && !ext_mode && !rx_crc_ok) |=> !is_protected);

    a_r5_arm_ext: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd[7] && listen && rx_done && ext_mode) |=> is_protected);

    a_r8_leave_listen: assert property (@(posedge clk) disable iff (rst)
        !listen |=> !is_protected);

    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd[7] |=> !is_protected);

    a_r2_reg_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 6'h0C) |=> $stable(cfg_rd));
endmodule

bind fbuf_guard fbg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .cfg_rd       (cfg_rd),
    .trx_state    (trx_state),
    .rx_done      (rx_done),
    .rx_crc_ok    (rx_crc_ok),
    .ext_mode     (ext_mode),
    .is_protected (is_protected)
);

// File: tb/sim_fbuf_guard.sv
module sim_fbuf_guard;
    localparam int CLK_P = 10;
    localparam int NVEC  = 8;
    // vector: {state[4:0], ext_mode, crc_ok, expected_protected}
    localparam logic [7:0] VEC [NVEC] = '{
        {5'h06, 1'b0, 1'b1, 1'b1},
        {5'h06, 1'b0, 1'b0, 1'b0},
        {5'h16, 1'b0, 1'b1, 1'b1},
        {5'h16, 1'b1, 1'b0, 1'b1},
        {5'h06, 1'b1, 1'b1, 1'b1},
        {5'h08, 1'b0, 1'b1, 1'b0},
        {5'h08, 1'b1, 1'b0, 1'b0},
        {5'h16, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 0;
    logic       rst = 1;
    logic       reg_we = 0;
    logic [5:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] cfg_rd;
    logic [4:0] trx_state = 5'h08;
    logic       rx_done = 0, rx_crc_ok = 0, ext_mode = 0;
    logic       host_cs_n = 1, host_fb_rd = 0;
    logic       air_wr_en, is_protected;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #(CLK_P/2) clk = ~clk;

    fbuf_guard u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_rd(cfg_rd), .trx_state(trx_state),
        .rx_done(rx_done), .rx_crc_ok(rx_crc_ok), .ext_mode(ext_mode),
        .host_cs_n(host_cs_n), .host_fb_rd(host_fb_rd),
        .air_wr_en(air_wr_en), .is_protected(is_protected)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 0;
    endtask

    task automatic frame(input logic crc, input logic ext);
        rx_done = 1; rx_crc_ok = crc; ext_mode = ext;
        step(1);
        rx_done = 0;
    endtask

    task automatic arm_now();
        trx_state = 5'h06;
        frame(1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        chk("R1 protected", {7'b0, is_protected}, 8'h00);
        chk("R1 air_wr_en", {7'b0, air_wr_en}, 8'h01);
        chk("R1 cfg_rd", cfg_rd, 8'h00);

        // R2 register layout and address decode
        wr_reg(6'h0C, 8'hFF);
        chk("R2 reserved read zero", cfg_rd, 8'h83);
        wr_reg(6'h0D, 8'h00);
        chk("R2 other address ignored", cfg_rd, 8'h83);
        wr_reg(6'h0C, 8'h81);
        chk("R2 rate field", cfg_rd, 8'h81);

        // table: R3 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            trx_state = VEC[v][7:3];
            step(1);
            frame(VEC[v][1], VEC[v][2]);
            chk($sformatf("R3/R4/R5 vec%0d protected", v), {7'b0, is_protected}, {7'b0, VEC[v][0]});
            chk($sformatf("R3/R4/R5 vec%0d air_wr_en", v), {7'b0, air_wr_en}, {7'b0, ~VEC[v][0]});
            trx_state = 5'h08;
            step(1);
            chk($sformatf("R8 vec%0d leave listen", v), {7'b0, is_protected}, 8'h00);
        end

        // R6 frame-buffer read release, three-edge latency
        arm_now();
        host_cs_n = 0; host_fb_rd = 1;
        step(4);
        host_cs_n = 1; host_fb_rd = 0;
        step(2);
        chk("R6 held before latency", {7'b0, is_protected}, 8'h01);
        step(1);
        chk("R6 released", {7'b0, is_protected}, 8'h00);

        // R7 non-buffer access keeps protection
        arm_now();
        host_cs_n = 0; host_fb_rd = 0;
        step(4);
        host_cs_n = 1;
        step(6);
        chk("R7 register access no release", {7'b0, is_protected}, 8'h01);

        // R11 arm in the release cycle
        host_cs_n = 0; host_fb_rd = 1;
        step(4);
        host_cs_n = 1; host_fb_rd = 0;
        step(2);
        frame(1'b1, 1'b0);
        chk("R11 arm beats release", {7'b0, is_protected}, 8'h01);
        step(3);
        chk("R11 still held", {7'b0, is_protected}, 8'h01);

        // R9 clearing enable releases
        wr_reg(6'h0C, 8'h01);
        chk("R9 one edge after write", {7'b0, is_protected}, 8'h01);
        step(1);
        chk("R9 released", {7'b0, is_protected}, 8'h00);

        // R10 disabled guard never arms
        frame(1'b1, 1'b0);
        chk("R10 no arm basic", {7'b0, is_protected}, 8'h00);
        frame(1'b0, 1'b1);
        chk("R10 air_wr_en kept", {7'b0, air_wr_en}, 8'h01);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule